// File: doc/BRIEF.md
# Program Break Controller with Single-Level Interrupt and Supervisor Trap

This block decides, at each instruction boundary of an 18-bit processor, whether the instruction presented for execution runs or is replaced by a program break. It holds three mode bits: interrupt enable, trap mode and extend mode. A break has one of two causes. A device interrupt is due when interrupts are enabled and any connected device flag is set. A supervisor trap is due when trap mode is on and the instruction belongs to a guarded class. Both causes use the same break path. The controller builds the word that saves the processor state, asks for it to be written to location 0, and loads the program counter with the vector for the cause.

The CPU presents one instruction per `exec_stb` pulse. It gives the instruction word, its address, the link bit and, for an execute instruction, the opcode of the word that instruction would run. The controller answers in the same cycle. It asserts `instr_go` to let the instruction run, or it asserts `brk_we` and `pc_load` to break instead. The mode bits change on the clock edge that closes that cycle. Only one interrupt level exists: a break turns interrupts off, and software turns them back on.

Top module: `brk_ctrl`

## Requirements
- R1: After reset, interrupt enable, trap mode and extend mode are all 0, and no break is requested.
- R2: An executed word 700002 (octal) clears interrupt enable. An executed 700042 sets it. An executed 700062 sets it and also loads trap mode from `trap_sw`, so trap mode becomes 1 only when the switch is on.
- R3: On an interrupt break, `brk_we` and `pc_load` are 1 and `instr_go` is 0. `brk_word` holds link in bit 17, extend in bit 16, trap mode in bit 15 and the unchanged `pc` in bits 14:0. `pc_next` is 1.
- R4: After an interrupt break, interrupt enable, trap mode and extend mode are all 0.
- R5: A device flag set while interrupts are off causes no break. It stays pending and is serviced once interrupts are on again.
- R6: The instruction that directly follows an executed enable (700042 or 700062) always completes before a pending interrupt is taken.
- R7: In trap mode, three kinds of instruction are trapped. The first is any I/O instruction, opcode bits 17:14 = 1110. The second is an execute instruction, bits 17:14 = 1000, whose target opcode `subj_op` is also 1000. The third is an operate instruction, bits 17:14 = 1111, with the halt bit (bit 5) set.
- R8: On a trap break, `brk_word` holds link, extend and trap bit = 1 in bits 17:15. Bits 14:0 hold `pc`+1, wrapping from 7FFF hex to 0. `pc_next` is 2. Afterwards extend mode is 1 and interrupt enable and trap mode are 0.
- R9: If a trap and an interrupt are both due in the same cycle, the trap is taken and the instruction does not run.
- R10: With `exec_stb` low, no break is requested and no mode bit changes.
- R11: An operate instruction without the halt bit, and an execute instruction whose target is not an execute, are not trapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_stb | input | 1 | Instruction boundary: `instr` is about to execute |
| instr | input | 18 | Instruction word presented for execution |
| subj_op | input | 4 | Opcode field of the word an execute instruction would run |
| pc | input | 15 | Address of `instr` |
| link | input | 1 | Current link bit |
| trap_sw | input | 1 | Console trap-permit switch |
| dev_flags | input | 14 | Device ready flags |
| brk_we | output | 1 | Write `brk_word` to location 0 |
| brk_word | output | 18 | Saved state word |
| pc_load | output | 1 | Load `pc_next` into the program counter |
| pc_next | output | 15 | Break vector: 1 for interrupt, 2 for trap |
| instr_go | output | 1 | Presented instruction may execute |
| ie_o | output | 1 | Interrupt enable |
| trap_o | output | 1 | Trap mode |
| ext_o | output | 1 | Extend mode |

## Verification
The hardest state to reach from the ports is a cycle in which a trap and an interrupt are both due. Trap mode can only be turned on by 700062, and that word also arms the one-instruction hold on interrupts. The bench therefore enables both modes with the switch on, runs one harmless operate word to use up the hold while no flag is raised, then raises a flag and presents an I/O word in the same cycle. The hold itself is exercised by setting a flag while interrupts are off, enabling, and checking that exactly one further instruction runs before the break.

// File: rtl/brk_ctrl_pkg.sv
package brk_ctrl_pkg;

  localparam int INSTR_W = 18;

  localparam logic [3:0] OP_XCT = 4'b1000;
  localparam logic [3:0] OP_IOT = 4'b1110;
  localparam logic [3:0] OP_OPR = 4'b1111;
  localparam int         HALT_BIT = 5;

  localparam logic [INSTR_W-1:0] W_INT_OFF  = 18'o700002;
  localparam logic [INSTR_W-1:0] W_INT_ON   = 18'o700042;
  localparam logic [INSTR_W-1:0] W_TRAP_ON  = 18'o700062;

  typedef enum logic [1:0] {
    MC_NONE,
    MC_INT_OFF,
    MC_INT_ON,
    MC_TRAP_ON
  } mode_cmd_e;

  function automatic mode_cmd_e decode_cmd(input logic [INSTR_W-1:0] w);
    if (w == W_INT_OFF)      return MC_INT_OFF;
    else if (w == W_INT_ON)  return MC_INT_ON;
    else if (w == W_TRAP_ON) return MC_TRAP_ON;
    else                     return MC_NONE;
  endfunction

  function automatic logic is_guarded(input logic [INSTR_W-1:0] w,
                                      input logic [3:0] target_op);
    logic [3:0] op;
    op = w[INSTR_W-1 -: 4];
    return (op == OP_IOT) ||
           (op == OP_XCT && target_op == OP_XCT) ||
           (op == OP_OPR && w[HALT_BIT]);
  endfunction

endpackage

// File: rtl/brk_decode.sv
module brk_decode
  import brk_ctrl_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  logic [3:0]         subj_op,
  input  logic               trap_md,
  output mode_cmd_e          cmd,
  output logic               trap_hit
);
  always_comb begin
    cmd      = decode_cmd(instr);
    trap_hit = trap_md && is_guarded(instr, subj_op);
  end
endmodule

// File: rtl/brk_arbiter.sv
module brk_arbiter (
  input  logic exec_stb,
  input  logic trap_hit,
  input  logic int_due,
  output logic take_trap,
  output logic take_int,
  output logic go
);
  always_comb begin
    take_trap = exec_stb && trap_hit;
    take_int  = exec_stb && int_due && !trap_hit;
    go        = exec_stb && !trap_hit && !int_due;
  end
endmodule

// File: rtl/brk_mode_regs.sv
module brk_mode_regs
  import brk_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go,
  input  mode_cmd_e cmd,
  input  logic      trap_sw,
  input  logic      take_trap,
  input  logic      take_int,
  output logic      ie,
  output logic      trap_md,
  output logic      ext_md,
  output logic      defer
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie      <= 1'b0;
      trap_md <= 1'b0;
      ext_md  <= 1'b0;
      defer   <= 1'b0;
    end else if (take_trap) begin
      ie      <= 1'b0;
      trap_md <= 1'b0;
      ext_md  <= 1'b1;
      defer   <= 1'b0;
    end else if (take_int) begin
      ie      <= 1'b0;
      trap_md <= 1'b0;
      ext_md  <= 1'b0;
      defer   <= 1'b0;
    end else if (go) begin
      defer <= 1'b0;
      unique case (cmd)
        MC_INT_OFF: ie <= 1'b0;
        MC_INT_ON: begin
          ie    <= 1'b1;
          defer <= 1'b1;
        end
        MC_TRAP_ON: begin
          ie      <= 1'b1;
          defer   <= 1'b1;
          trap_md <= trap_sw;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl
  import brk_ctrl_pkg::*;
#(
  parameter int                AW        = 15,
  parameter int                NFLAG     = 14,
  parameter logic [NFLAG-1:0]  CONN_MASK = '1,
  localparam int               W         = AW + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_stb,
  input  logic [INSTR_W-1:0] instr,
  input  logic [3:0]         subj_op,
  input  logic [AW-1:0]      pc,
  input  logic               link,
  input  logic               trap_sw,
  input  logic [NFLAG-1:0]   dev_flags,
  output logic               brk_we,
  output logic [W-1:0]       brk_word,
  output logic               pc_load,
  output logic [AW-1:0]      pc_next,
  output logic               instr_go,
  output logic               ie_o,
  output logic               trap_o,
  output logic               ext_o
);
  localparam logic [AW-1:0] VEC_INT  = AW'(1);
  localparam logic [AW-1:0] VEC_TRAP = AW'(2);

  function automatic logic [W-1:0] pack_state(input logic l, input logic e,
                                              input logic t, input logic [AW-1:0] p);
    return {l, e, t, p};
  endfunction

  mode_cmd_e cmd;
  logic trap_hit, int_due, flag_any;
  logic take_trap, take_int, go;
  logic ie, trap_md, ext_md, defer;
  logic [AW-1:0] saved_pc;

  brk_decode u_dec (
    .instr    (instr),
    .subj_op  (subj_op),
    .trap_md  (trap_md),
    .cmd      (cmd),
    .trap_hit (trap_hit)
  );

  assign flag_any = |(dev_flags & CONN_MASK);
  assign int_due  = ie && !defer && flag_any;

  brk_arbiter u_arb (
    .exec_stb  (exec_stb),
    .trap_hit  (trap_hit),
    .int_due   (int_due),
    .take_trap (take_trap),
    .take_int  (take_int),
    .go        (go)
  );

  brk_mode_regs u_modes (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .cmd       (cmd),
    .trap_sw   (trap_sw),
    .take_trap (take_trap),
    .take_int  (take_int),
    .ie        (ie),
    .trap_md   (trap_md),
    .ext_md    (ext_md),
    .defer     (defer)
  );

  always_comb begin
    saved_pc = take_trap ? pc + AW'(1) : pc;
    brk_we   = take_trap || take_int;
    pc_load  = brk_we;
    pc_next  = take_trap ? VEC_TRAP : VEC_INT;
    brk_word = pack_state(link, ext_md, trap_md, saved_pc);
    instr_go = go;
    ie_o     = ie;
    trap_o   = trap_md;
    ext_o    = ext_md;
  end
endmodule

// File: rtl/brk_ctrl_chk.sv
module brk_ctrl_chk
  import brk_ctrl_pkg::*;
#(
  parameter int AW = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               exec_stb,
  input logic [INSTR_W-1:0] instr,
  input logic               brk_we,
  input logic               pc_load,
  input logic [AW-1:0]      pc_next,
  input logic               instr_go,
  input logic               ie_o,
  input logic               trap_o,
  input logic               ext_o,
  input logic               take_trap,
  input logic               take_int
);
  // R3
  break_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_we |-> (!instr_go && pc_load));

  // R3
  int_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_int |-> (pc_next == AW'(1)));

  // R8
  trap_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |-> (pc_next == AW'(2)));

  // R4
  int_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_int |=> (!ie_o && !ext_o && !trap_o));

  // R8
  trap_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> (ext_o && !ie_o && !trap_o));

  // R9
  trap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |-> !take_int);

  // R2
  int_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_go && instr == W_INT_ON) |=> ie_o);

  // R2
  int_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_go && instr == W_INT_OFF) |=> !ie_o);

  // R6
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(instr_go && (instr == W_INT_ON || instr == W_TRAP_ON)) && exec_stb) |-> !take_int);

  // R10
  idle_nobreak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_stb |-> (!brk_we && !instr_go));

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_stb |=> ($stable(ie_o) && $stable(trap_o) && $stable(ext_o)));
endmodule

bind brk_ctrl brk_ctrl_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .exec_stb  (exec_stb),
  .instr     (instr),
  .brk_we    (brk_we),
  .pc_load   (pc_load),
  .pc_next   (pc_next),
  .instr_go  (instr_go),
  .ie_o      (ie_o),
  .trap_o    (trap_o),
  .ext_o     (ext_o),
  .take_trap (take_trap),
  .take_int  (take_int)
);

// File: tb/brk_ctrl_test.sv
`timescale 1ns/1ps
module brk_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_stb = 1'b0;
  logic [17:0] instr = '0;
  logic [3:0]  subj_op = '0;
  logic [14:0] pc = '0;
  logic        link = 1'b0;
  logic        trap_sw = 1'b0;
  logic [13:0] dev_flags = '0;
  logic        brk_we, pc_load, instr_go, ie_o, trap_o, ext_o;
  logic [17:0] brk_word;
  logic [14:0] pc_next;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic        s_we, s_load, s_go;
  logic [17:0] s_word;
  logic [14:0] s_next;

  localparam logic [17:0] I_OFF  = 18'o700002;
  localparam logic [17:0] I_ON   = 18'o700042;
  localparam logic [17:0] I_TON  = 18'o700062;
  localparam logic [17:0] I_NOP  = 18'o740000;
  localparam logic [17:0] I_HLT  = 18'o740040;
  localparam logic [17:0] I_XCT  = 18'o400123;
  localparam logic [17:0] I_SKP  = 18'o700101;
  localparam logic [3:0]  OPX    = 4'b1000;
  localparam logic [3:0]  OPLAC  = 4'b0010;

  always #2.5 clk = ~clk;

  brk_ctrl uut (
    .clk(clk), .rst_n(rst_n), .exec_stb(exec_stb), .instr(instr),
    .subj_op(subj_op), .pc(pc), .link(link), .trap_sw(trap_sw),
    .dev_flags(dev_flags), .brk_we(brk_we), .brk_word(brk_word),
    .pc_load(pc_load), .pc_next(pc_next), .instr_go(instr_go),
    .ie_o(ie_o), .trap_o(trap_o), .ext_o(ext_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // present one instruction for one cycle; capture same-cycle outputs
  task automatic issue(input logic [17:0] w, input logic [3:0] sop,
                       input logic [14:0] p, input logic l);
    @(negedge clk);
    exec_stb = 1'b1; instr = w; subj_op = sop; pc = p; link = l;
    #1;
    s_we = brk_we; s_load = pc_load; s_go = instr_go;
    s_word = brk_word; s_next = pc_next;
    @(posedge clk);
    #1;
    exec_stb = 1'b0;
  endtask

  function automatic logic [17:0] exp_word(input logic l, input logic e,
                                           input logic t, input logic [14:0] p);
    logic [17:0] r;
    r = 18'(p);
    r[17] = l; r[16] = e; r[15] = t;
    return r;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ie", ie_o, 0);
    chk("R1 trap", trap_o, 0);
    chk("R1 ext", ext_o, 0);
    chk("R1 brk_we", brk_we, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_modes();
    trap_sw = 1'b0;
    issue(I_ON, 0, 15'd10, 0);
    chk("R2 ion runs", s_go, 1);
    chk("R2 ion sets ie", ie_o, 1);
    issue(I_OFF, 0, 15'd11, 0);
    chk("R2 iof clears ie", ie_o, 0);
    issue(I_TON, 0, 15'd12, 0);
    chk("R2 iton sets ie", ie_o, 1);
    chk("R2 iton no switch keeps trap off", trap_o, 0);
    issue(I_OFF, 0, 15'd13, 0);
    chk("R2 iof again", ie_o, 0);
  endtask

  task automatic t_pending();
    dev_flags = 14'h0040;
    issue(I_NOP, 0, 15'd99, 0);
    chk("R5 no break while off", s_we, 0);
    chk("R5 instr runs while off", s_go, 1);
    issue(I_ON, 0, 15'd99, 0);
    chk("R5 ion itself runs", s_go, 1);
    issue(I_NOP, 0, 15'd100, 0);
    chk("R6 instr after ion runs", s_go, 1);
    chk("R6 no break after ion", s_we, 0);
    issue(I_NOP, 0, 15'd101, 1);
    chk("R3 break taken", s_we, 1);
    chk("R3 pc load", s_load, 1);
    chk("R3 not executed", s_go, 0);
    chk("R3 word", s_word, exp_word(1, 0, 0, 15'd101));
    chk("R3 vector", s_next, 1);
    chk("R4 ie off", ie_o, 0);
    chk("R4 ext off", ext_o, 0);
    chk("R4 trap off", trap_o, 0);
    dev_flags = '0;
  endtask

  task automatic t_trap();
    trap_sw = 1'b1;
    issue(I_TON, 0, 15'd150, 0);
    chk("R2 iton with switch sets trap", trap_o, 1);
    issue(I_NOP, 0, 15'd151, 0);
    chk("R11 opr without halt runs", s_go, 1);
    chk("R11 opr without halt no trap", s_we, 0);
    issue(I_XCT, OPLAC, 15'd152, 0);
    chk("R11 xct of non-xct runs", s_go, 1);
    chk("R11 xct of non-xct no trap", s_we, 0);
    issue(I_XCT, OPX, 15'd200, 0);
    chk("R7 xct of xct trapped", s_we, 1);
    chk("R8 word", s_word, exp_word(0, 0, 1, 15'd201));
    chk("R8 vector", s_next, 2);
    chk("R8 ext on", ext_o, 1);
    chk("R8 ie off", ie_o, 0);
    chk("R8 trap off", trap_o, 0);
    issue(I_TON, 0, 15'd300, 0);
    issue(I_HLT, 0, 15'h7FFF, 0);
    chk("R7 halt trapped", s_we, 1);
    chk("R8 wrap word", s_word, exp_word(0, 1, 1, 15'h0000));
    issue(I_TON, 0, 15'd4, 0);
    issue(I_SKP, 0, 15'd5, 1);
    chk("R7 iot trapped", s_we, 1);
    chk("R7 iot not executed", s_go, 0);
    chk("R8 iot word", s_word, exp_word(1, 1, 1, 15'd6));
    trap_sw = 1'b0;
    issue(I_SKP, 0, 15'd7, 0);
    chk("R7 iot runs outside trap mode", s_go, 1);
  endtask

  task automatic t_priority();
    trap_sw = 1'b1;
    issue(I_TON, 0, 15'd30, 0);
    issue(I_NOP, 0, 15'd31, 0);
    dev_flags = 14'h0001;
    issue(I_SKP, 0, 15'd20, 0);
    chk("R9 trap wins", s_word, exp_word(0, 1, 1, 15'd21));
    chk("R9 trap vector", s_next, 2);
    chk("R9 not executed", s_go, 0);
    issue(I_NOP, 0, 15'd2, 0);
    chk("R5 flag pending, ie off", s_we, 0);
    dev_flags = '0;
    trap_sw = 1'b0;
  endtask

  task automatic t_idle();
    issue(I_ON, 0, 15'd40, 0);
    issue(I_NOP, 0, 15'd41, 0);
    @(negedge clk);
    dev_flags = 14'h2000;
    instr = I_OFF;
    #1;
    chk("R10 no break when idle", brk_we, 0);
    repeat (3) @(posedge clk);
    #1;
    chk("R10 ie unchanged", ie_o, 1);
    chk("R10 ext unchanged", ext_o, 1);
    issue(I_NOP, 0, 15'd42, 0);
    chk("R10 interrupt once strobed", s_we, 1);
    chk("R3 word with ext", s_word, exp_word(0, 1, 0, 15'd42));
    dev_flags = '0;
  endtask

  initial begin
    t_reset();
    t_modes();
    t_pending();
    t_trap();
    t_priority();
    t_idle();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule